// File: doc/BRIEF.md
# Single-Cell Fault-Injecting RAM

This block is a synchronous, single-port, one-bit-wide RAM that can misbehave on purpose. It is meant for trying out memory test sequences: the test under study drives ordinary writes and reads, and the wrapper makes one chosen cell act like a defective one. The fault is described by three fields and an enable: a 4-bit class code, a polarity bit and a target address. Only one fault exists at a time. Every other address behaves like a healthy memory.

On each clock edge the target cell is looked at together with the operation that hits it. The fault logic then decides on its own what value the cell keeps and what value a read returns. Reads are registered. A separate peek address lets a checker see the raw stored bit of any cell without issuing an access.

Top module: `fault_inject_ram`

## Requirements
- R1: Reset is synchronous and active-high. It clears every cell to 0 and drops `rd_valid`. While reset is held, no fault changes a cell, even when a state fault with polarity 0 is enabled.
- R2: Without a fault, a write stores `wr_bit` at `addr` on the clock edge. A read returns the stored bit on `rd_bit` one cycle after `rd_en`, with `rd_valid` high in that cycle only. Write and read to the same address in one cycle is not a legal input.
- R3: Class code 0, a low `flt_en`, and the unused codes 8 to 15 all give fault-free behaviour. Addresses other than `flt_addr` are always fault-free.
- R4: Code 1 is the state fault. A target cell that holds `flt_pol` becomes the inverse at the next clock edge, unless that edge writes it, and a read in that cycle already returns the inverse.
- R5: Code 2 is the transition fault. Writing `flt_pol` into a target cell that holds the inverse of `flt_pol` leaves the cell unchanged. Polarity 1 blocks the 0 to 1 change and polarity 0 blocks the 1 to 0 change.
- R6: Code 3 is the write-destructive fault. Writing `flt_pol` into a target cell that already holds `flt_pol` stores the inverse.
- R7: Code 4 is the read-destructive fault. A read of a target cell holding `flt_pol` inverts the cell and returns the new, wrong value.
- R8: Code 5 is the deceptive read-destructive fault. A read of a target cell holding `flt_pol` returns the correct value and inverts the cell.
- R9: Code 6 is the incorrect-read fault. A read of a target cell holding `flt_pol` returns the inverse and leaves the cell unchanged.
- R10: Code 7 is the stuck-at fault. The target cell is forced to `flt_pol` at every edge, writes cannot change it, and reads return `flt_pol`. Polarity 0 covers the union of the state, up-transition and write-destructive behaviours that pull the cell to 0. Polarity 1 is the mirror case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Access address |
| wr_en | input | 1 | Write strobe |
| wr_bit | input | 1 | Data bit to write |
| rd_en | input | 1 | Read strobe |
| flt_en | input | 1 | Enables the configured fault |
| flt_kind | input | 4 | Fault class code (0 none, 1 to 7 as in R4 to R10) |
| flt_pol | input | 1 | Sensitizing or forced value of the fault |
| flt_addr | input | ADDR_W | Address of the faulty cell |
| peek_addr | input | ADDR_W | Address whose stored bit appears on `peek_bit` |
| rd_bit | output | 1 | Registered read data |
| rd_valid | output | 1 | High one cycle after a read strobe |
| peek_bit | output | 1 | Raw stored bit at `peek_addr` |

## Verification
The bench runs each fault class with both polarities on a fresh cell. It checks the stored bit as well as the returned bit, because the deceptive and incorrect-read classes differ only in which of the two is wrong. A design that mixed them up would return the right value and keep a corrupted cell, or the reverse. The state fault is checked with a write of the sensitizing value followed by an idle cycle: a design that flipped the cell at the wrong time, or let a read see the stale value, would report the written value. A state fault with polarity 0 is also kept enabled through reset, so a design that lets the fault act during reset would leave the cell at 1. Unused class codes and neighbouring addresses are also exercised, so a fault that leaks past its address or its code shows up as a corrupted neighbour.

// File: rtl/fir_pkg.sv
package fir_pkg;

    typedef enum logic [3:0] {
        FK_NONE   = 4'd0,
        FK_STATE  = 4'd1,
        FK_TRANS  = 4'd2,
        FK_WDEST  = 4'd3,
        FK_RDEST  = 4'd4,
        FK_DRDEST = 4'd5,
        FK_IREAD  = 4'd6,
        FK_STUCK  = 4'd7
    } flt_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic wbit;
    } cell_op_t;

    typedef struct packed {
        logic nxt;
        logic rbit;
    } cell_res_t;

    function automatic logic kind_live(input logic [3:0] k);
        return (k != 4'd0) && (k <= 4'd7);
    endfunction

    // Value the target cell presents before any operation this cycle.
    function automatic logic present_value(input flt_kind_e k, input logic p,
                                           input logic cur);
        logic v;
        v = cur;
        if (k == FK_STATE && cur == p) v = ~p;
        if (k == FK_STUCK)             v = p;
        return v;
    endfunction

    // Stored and returned value of the target cell under the configured fault.
    function automatic cell_res_t apply_fault(input flt_kind_e k, input logic p,
                                              input logic cur, input cell_op_t op);
        cell_res_t r;
        logic      eff;
        eff    = present_value(k, p, cur);
        r.nxt  = eff;
        r.rbit = eff;
        if (op.wr) begin
            r.nxt = op.wbit;
            case (k)
                FK_TRANS: if (eff != p && op.wbit == p) r.nxt = eff;
                FK_WDEST: if (eff == p && op.wbit == p) r.nxt = ~p;
                FK_STUCK: r.nxt = p;
                default:  ;
            endcase
        end else if (op.rd) begin
            case (k)
                FK_RDEST: if (eff == p) begin
                    r.nxt  = ~p;
                    r.rbit = ~p;
                end
                FK_DRDEST: if (eff == p) r.nxt = ~p;
                FK_IREAD:  if (eff == p) r.rbit = ~p;
                default:   ;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/fir_fault_unit.sv
module fir_fault_unit
    import fir_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              flt_en,
    input  logic [3:0]        flt_kind,
    input  logic              flt_pol,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              rd_en,
    input  logic              tgt_cur,
    output logic              active,
    output logic              hit,
    output cell_res_t         res
);
    cell_op_t op;

    always_comb begin
        active  = flt_en && kind_live(flt_kind);
        hit     = active && (addr == flt_addr);
        op.wr   = wr_en && (addr == flt_addr);
        op.rd   = rd_en && (addr == flt_addr);
        op.wbit = wr_bit;
        if (active) res = apply_fault(flt_kind_e'(flt_kind), flt_pol, tgt_cur, op);
        else        res = '{nxt: tgt_cur, rbit: tgt_cur};
    end
endmodule

// File: rtl/fir_cell_array.sv
module fir_cell_array #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_bit,
    input  logic              tgt_own,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic              tgt_nxt,
    output logic [DEPTH-1:0]  cells
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        always_ff @(posedge clk) begin
            if (rst)                              cells[i] <= 1'b0;
            else if (tgt_own && tgt_addr == IDX)  cells[i] <= tgt_nxt;
            else if (wr_en && addr == IDX)        cells[i] <= wr_bit;
        end
    end
endmodule

// File: rtl/fir_read_port.sv
module fir_read_port #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DEPTH-1:0]  cells,
    input  logic              tgt_hit,
    input  logic              tgt_rbit,
    output logic              rd_bit,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bit   <= 1'b0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_bit <= tgt_hit ? tgt_rbit : cells[addr];
        end
    end
endmodule

// File: rtl/fault_inject_ram.sv
module fault_inject_ram
    import fir_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              wr_bit,
    input  logic              rd_en,
    input  logic              flt_en,
    input  logic [3:0]        flt_kind,
    input  logic              flt_pol,
    input  logic [ADDR_W-1:0] flt_addr,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic              rd_bit,
    output logic              rd_valid,
    output logic              peek_bit
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] cell_q;
    logic             f_active;
    logic             f_hit;
    cell_res_t        f_res;

    fir_fault_unit #(.ADDR_W(ADDR_W)) u_fault (
        .flt_en   (flt_en),
        .flt_kind (flt_kind),
        .flt_pol  (flt_pol),
        .flt_addr (flt_addr),
        .addr     (addr),
        .wr_en    (wr_en),
        .wr_bit   (wr_bit),
        .rd_en    (rd_en),
        .tgt_cur  (cell_q[flt_addr]),
        .active   (f_active),
        .hit      (f_hit),
        .res      (f_res)
    );

    fir_cell_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_bit   (wr_bit),
        .tgt_own  (f_active),
        .tgt_addr (flt_addr),
        .tgt_nxt  (f_res.nxt),
        .cells    (cell_q)
    );

    fir_read_port #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .addr     (addr),
        .cells    (cell_q),
        .tgt_hit  (f_hit),
        .tgt_rbit (f_res.rbit),
        .rd_bit   (rd_bit),
        .rd_valid (rd_valid)
    );

    assign peek_bit = cell_q[peek_addr];
endmodule

// File: rtl/fir_checker.sv
module fir_checker #(
    parameter int ADDR_W = 4,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              wr_bit,
    input logic              rd_en,
    input logic              flt_en,
    input logic [3:0]        flt_kind,
    input logic              flt_pol,
    input logic [ADDR_W-1:0] flt_addr,
    input logic              rd_bit,
    input logic              rd_valid,
    input logic [DEPTH-1:0]  cells
);
    logic on_target;
    assign on_target = flt_en && flt_kind >= 4'd1 && flt_kind <= 4'd7 && addr == flt_addr;

    assert_rdvalid_R2: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    assert_clean_read_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && !on_target) |=> rd_bit == $past(cells[addr]));

    assert_clean_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !on_target) |=> cells[$past(addr)] == $past(wr_bit));

    assert_state_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (flt_en && flt_kind == 4'd1 && !(wr_en && addr == flt_addr)
         && cells[flt_addr] == flt_pol)
        |=> cells[$past(flt_addr)] != $past(flt_pol));

    assert_iread_keep_R9: assert property (@(posedge clk) disable iff (rst)
        (flt_en && flt_kind == 4'd6 && rd_en && !wr_en && addr == flt_addr
         && cells[flt_addr] == flt_pol)
        |=> (rd_bit != $past(flt_pol)) && (cells[$past(flt_addr)] == $past(flt_pol)));

    assert_stuck_R10: assert property (@(posedge clk) disable iff (rst)
        (flt_en && flt_kind == 4'd7) |=> cells[$past(flt_addr)] == $past(flt_pol));
endmodule

bind fault_inject_ram fir_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_bit   (wr_bit),
    .rd_en    (rd_en),
    .flt_en   (flt_en),
    .flt_kind (flt_kind),
    .flt_pol  (flt_pol),
    .flt_addr (flt_addr),
    .rd_bit   (rd_bit),
    .rd_valid (rd_valid),
    .cells    (cell_q)
);

// File: tb/sim_fault_inject_ram.sv
module sim_fault_inject_ram;
    localparam int AW   = 4;
    localparam int NC   = 1 << AW;
    localparam int OP_I = 0;
    localparam int OP_W = 1;
    localparam int OP_R = 2;

    typedef struct packed {
        logic       rs;
        logic       en;
        logic [3:0] kind;
        logic       pol;
        logic [1:0] op;
        logic [3:0] a;
        logic       wb;
        logic       xr;
        logic       xc;
        logic [3:0] req;
    } vec_t;

    function automatic vec_t row(input int rs, en, kind, pol, op, a, wb, xr, xc, req);
        vec_t v;
        v.rs = 1'(rs); v.en = 1'(en); v.kind = 4'(kind); v.pol = 1'(pol);
        v.op = 2'(op); v.a = 4'(a); v.wb = 1'(wb); v.xr = 1'(xr);
        v.xc = 1'(xc); v.req = 4'(req);
        return v;
    endfunction

    localparam int NROW = 59;
    // Target cell is address 5 throughout; rows with rs=1 reset the array (R1).
    localparam vec_t TBL [NROW] = '{
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,0,0,0,OP_W,3,1,0,1,2),   // R2 plain write
        row(0,0,0,0,OP_R,3,0,1,1,2),   // R2 plain read
        row(0,0,0,0,OP_W,5,1,0,1,3),   // R3 fault disabled
        row(0,0,0,0,OP_R,5,0,1,1,3),
        row(0,0,0,0,OP_W,5,0,0,0,3),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,1,1,OP_I,5,0,0,0,4),   // R4 SF pol1, cell 0: no flip
        row(0,1,1,1,OP_W,5,1,0,1,4),   // R4 write 1 stores 1
        row(0,1,1,1,OP_I,5,0,0,0,4),   // R4 then flips to 0
        row(0,1,1,1,OP_W,5,1,0,1,4),
        row(0,1,1,1,OP_R,5,0,0,0,4),   // R4 read sees flipped value
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,1,0,OP_I,5,0,0,1,4),   // R4 SF pol0 flips 0 to 1
        row(0,1,1,0,OP_R,5,0,1,1,4),
        row(0,1,1,0,OP_I,4,0,0,0,3),   // R3 neighbour untouched
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,2,1,OP_W,5,1,0,0,5),   // R5 up transition blocked
        row(0,1,2,1,OP_R,5,0,0,0,5),
        row(0,1,2,1,OP_W,6,1,0,1,3),   // R3 other address writes
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,2,0,OP_W,5,1,0,1,5),   // R5 pol0 allows 0 to 1
        row(0,1,2,0,OP_W,5,0,0,1,5),   // R5 down transition blocked
        row(0,1,2,0,OP_R,5,0,1,1,5),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,3,0,OP_W,5,0,0,1,6),   // R6 w0 on 0 flips
        row(0,1,3,0,OP_W,5,0,0,0,6),   // R6 transition write works
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,3,1,OP_W,5,1,0,1,6),
        row(0,1,3,1,OP_W,5,1,0,0,6),   // R6 w1 on 1 flips
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,4,1,OP_W,5,1,0,1,7),
        row(0,1,4,1,OP_R,5,0,0,0,7),   // R7 read 1 returns 0, cell 0
        row(0,1,4,1,OP_R,5,0,0,0,7),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,4,0,OP_R,5,0,1,1,7),   // R7 pol0
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,5,0,OP_R,5,0,0,1,8),   // R8 correct data, cell flipped
        row(0,1,5,0,OP_R,5,0,1,1,8),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,5,1,OP_W,5,1,0,1,8),
        row(0,1,5,1,OP_R,5,0,1,0,8),   // R8 pol1
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,6,1,OP_W,5,1,0,1,9),
        row(0,1,6,1,OP_R,5,0,0,1,9),   // R9 wrong data, cell kept
        row(0,1,6,1,OP_R,5,0,0,1,9),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,6,0,OP_R,5,0,1,0,9),   // R9 pol0
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,7,0,OP_W,5,1,0,0,10),  // R10 stuck-at-0 ignores w1
        row(0,1,7,0,OP_R,5,0,0,0,10),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,7,1,OP_I,5,0,0,1,10),  // R10 stuck-at-1 forces 1
        row(0,1,7,1,OP_W,5,0,0,1,10),
        row(0,1,7,1,OP_R,5,0,1,1,10),
        row(1,0,0,0,OP_I,5,0,0,0,1),
        row(0,1,9,1,OP_W,5,1,0,1,3),   // R3 unused code 9 is fault-free
        row(0,1,9,1,OP_R,5,0,1,1,3),
        row(0,1,9,1,OP_W,5,0,0,0,3)
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic          wr_bit = 1'b0;
    logic          rd_en = 1'b0;
    logic          flt_en = 1'b0;
    logic [3:0]    flt_kind = 4'd0;
    logic          flt_pol = 1'b0;
    logic [AW-1:0] flt_addr = 4'd5;
    logic [AW-1:0] peek_addr = '0;
    logic          rd_bit;
    logic          rd_valid;
    logic          peek_bit;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    fault_inject_ram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_bit(wr_bit),
        .rd_en(rd_en), .flt_en(flt_en), .flt_kind(flt_kind), .flt_pol(flt_pol),
        .flt_addr(flt_addr), .peek_addr(peek_addr), .rd_bit(rd_bit),
        .rd_valid(rd_valid), .peek_bit(peek_bit)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    function automatic logic pat(input int i);
        return 1'(i & 1) ^ 1'((i >> 2) & 1);
    endfunction

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        string rq;
        @(negedge clk);
        @(negedge clk);
        // Table walk: drive at negedge, one edge, sample at the next negedge.
        for (int n = 0; n < NROW; n++) begin
            rst       = TBL[n].rs;
            flt_en    = TBL[n].en;
            flt_kind  = TBL[n].kind;
            flt_pol   = TBL[n].pol;
            addr      = TBL[n].a;
            peek_addr = TBL[n].a;
            wr_en     = (TBL[n].op == 2'(OP_W));
            rd_en     = (TBL[n].op == 2'(OP_R));
            wr_bit    = TBL[n].wb;
            @(posedge clk);
            @(negedge clk);
            rq = $sformatf("R%0d row%0d", TBL[n].req, n);
            chk(rq, "cell", peek_bit, TBL[n].xc);
            chk(rq, "valid", rd_valid, (TBL[n].op == 2'(OP_R)) && !TBL[n].rs);
            if (TBL[n].op == 2'(OP_R)) chk(rq, "rdata", rd_bit, TBL[n].xr);
        end
        wr_en = 1'b0; rd_en = 1'b0; rst = 1'b0;

        // R1: state fault pol0 held enabled through reset must not set the cell.
        flt_en = 1'b1; flt_kind = 4'd1; flt_pol = 1'b0; flt_addr = 4'd5;
        peek_addr = 4'd5; rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "cell under reset", peek_bit, 1'b0);
        chk("R1", "valid under reset", rd_valid, 1'b0);
        flt_en = 1'b0; flt_kind = 4'd0; rst = 1'b0;

        // R2: pattern over every address, fault disabled.
        for (int i = 0; i < NC; i++) begin
            addr = AW'(i); wr_bit = pat(i); wr_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int i = 0; i < NC; i++) begin
            addr = AW'(i); rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R2", $sformatf("sweep rdata a%0d", i), rd_bit, pat(i));
        end
        rd_en = 1'b0;

        // R10 with R3: stuck-at-1 at 5 forces it, neighbours keep their pattern.
        flt_en = 1'b1; flt_kind = 4'd7; flt_pol = 1'b1; peek_addr = 4'd5;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "forced cell", peek_bit, 1'b1);
        for (int i = 4; i <= 6; i += 2) begin
            addr = AW'(i); rd_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk("R3", $sformatf("neighbour a%0d", i), rd_bit, pat(i));
        end
        rd_en = 1'b0;
        finish_run();
    end
endmodule